// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block sequences the common and segment pins of a multiplexed liquid crystal panel. On each frame-rate tick it advances to the next common phase. For every pin it then emits a 2-bit code that tells the analog driver which rail to connect. Code 00 is ground, and codes 01, 10 and 11 are three bias rails, each one step lower than the last. Software picks one of three multiplex ratios:

- four commons with one-third bias;
- three commons with one-third bias;
- two commons with one-half bias.

The two highest common pins become extra segment pins when they are not needed as commons.

Pixel data comes from a flat register file with one 4-bit word per segment. Bit c of a word lights the pixel that sits under common c. Every full pass over the active commons flips the drive polarity, so the average voltage across each pixel is zero. A parameter mask can take some of the low segment pins away from the display and turn them into plain digital outputs.

Top module: `lcd_mux_seq`

## Requirements
- R1: After reset the phase is 0, the polarity is positive and the duty is four-common (duty code 00). While the display is off, every display pin reads 00.
- R2: While `disp_on` is 0:
  - every display pin (common pins and non-port segment pins) outputs 00;
  - the sequencer is held at phase 0 with positive polarity, so the first cycle after turn-on selects common 0 with code 11.
- R3: Each cycle with `tick` high advances the phase by one. The phase after the last active common is 0, and that step inverts the polarity. Cycles without `tick` keep both phase and polarity unchanged.
- R4: One-third bias commons. The selected common drives 11 at positive polarity and 00 at negative polarity. An unselected common drives 01 at positive polarity and 10 at negative polarity.
- R5: One-third bias segments. A segment whose bit for the current phase is 1 drives 00 at positive polarity and 11 at negative polarity. If the bit is 0, it drives 10 at positive polarity and 01 at negative polarity.
- R6: Duty code 10 (two commons, one-half bias):
  - unselected commons drive 10;
  - the selected common drives 11 at positive polarity and 00 at negative polarity;
  - a lit segment drives the level opposite the selected common, and a dark segment drives the same level as the selected common;
  - code 01 never appears on a display pin.
- R7: Duty code 01 (three commons). Phases run 0..2, and common pin 3 acts as segment S23, driven from data word NSEG.
- R8: Duty code 10. Phases run 0..1. Common pin 2 acts as segment S24, driven from word NSEG+1, and common pin 3 acts as S23, driven from word NSEG.
- R9: Duty code 11 behaves exactly like duty code 00.
- R10: A change of `duty_sel` takes effect on the next clock edge. That edge also restarts the sequence at phase 0 with positive polarity, whatever the tick.
- R11: A segment pin selected by `PORT_MASK` outputs 00 when its `port_val` bit is 1 and 11 when the bit is 0. This holds whatever the display state, phase or duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Frame-rate step pulse, one cycle wide |
| duty_sel | input | 2 | 00/11 four commons, 01 three commons, 10 two commons |
| disp_on | input | 1 | Display enable |
| seg_data | input | (NSEG+2)*4 = 100 | Pixel words; word k bit c lights segment k under common c |
| port_val | input | NPORT = 16 | Values for pins reused as digital outputs |
| com_lvl | output | 8 | Level codes of common pins 0..3, 2 bits each |
| seg_lvl | output | 2*NSEG = 46 | Level codes of segment pins S0..S(NSEG-1) |

## Verification
The bench builds the block with five segment pins and two port-capable pins, with only the second pin mapped as a port. This keeps every pin small enough to model in full on every cycle. Eight data patterns are swept under all four duty codes, including all-dark and all-lit panels, with ticks interleaved with idle cycles. Each sweep covers several wraps of the phase counter, both polarities, every common-to-segment role swap, display-off intervals and mid-frame duty changes. Both a port pin and ordinary segment pins sit in the same configuration, so leakage of display state into the port pin is visible.

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq #(
  parameter int NSEG = 23,
  parameter int NPORT = 16,
  parameter logic [NPORT-1:0] PORT_MASK = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic [1:0]               duty_sel,
  input  logic                     disp_on,
  input  logic [(NSEG+2)*4-1:0]    seg_data,
  input  logic [NPORT-1:0]         port_val,
  output logic [7:0]               com_lvl,
  output logic [2*NSEG-1:0]        seg_lvl
);

  localparam logic [1:0] GND = 2'b00;
  localparam logic [1:0] LOW = 2'b11;

  logic [1:0] duty_q;
  logic [1:0] phase;
  logic       pol;
  logic [1:0] last;
  logic       half;

  assign half = (duty_q == 2'b10);
  assign last = (duty_q == 2'b01) ? 2'd2 : (duty_q == 2'b10) ? 2'd1 : 2'd3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_q <= 2'b00;
      phase  <= 2'd0;
      pol    <= 1'b0;
    end else if (duty_sel != duty_q) begin
      duty_q <= duty_sel;
      phase  <= 2'd0;
      pol    <= 1'b0;
    end else if (!disp_on) begin
      phase  <= 2'd0;
      pol    <= 1'b0;
    end else if (tick) begin
      if (phase == last) begin
        phase <= 2'd0;
        pol   <= ~pol;
      end else begin
        phase <= phase + 2'd1;
      end
    end
  end

  logic [1:0] lv_sel, lv_uns, lv_on, lv_off;
  assign lv_sel = pol ? GND : LOW;
  assign lv_uns = half ? 2'b10 : (pol ? 2'b10 : 2'b01);
  assign lv_on  = pol ? LOW : GND;
  assign lv_off = half ? lv_sel : (pol ? 2'b01 : 2'b10);

  for (genvar c = 0; c < 4; c++) begin : g_com
    localparam int WD = (c == 3) ? NSEG : NSEG + 1;
    logic [3:0] word;
    logic       as_seg;
    assign word   = seg_data[4*WD +: 4];
    assign as_seg = (c == 3) ? (duty_q == 2'b01 || duty_q == 2'b10)
                  : (c == 2) ? half : 1'b0;
    assign com_lvl[2*c +: 2] = !disp_on ? GND
                             : as_seg   ? (word[phase] ? lv_on : lv_off)
                             : (phase == 2'(c)) ? lv_sel : lv_uns;
  end

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    logic [3:0] word;
    assign word = seg_data[4*k +: 4];
    if (k < NPORT) begin : g_low
      if (PORT_MASK[k]) begin : g_port
        assign seg_lvl[2*k +: 2] = port_val[k] ? GND : LOW;
      end else begin : g_disp
        assign seg_lvl[2*k +: 2] = !disp_on ? GND : (word[phase] ? lv_on : lv_off);
      end
    end else begin : g_high
      assign seg_lvl[2*k +: 2] = !disp_on ? GND : (word[phase] ? lv_on : lv_off);
    end
  end

  logic [1:0] cur_com;
  assign cur_com = com_lvl[{phase, 1'b0} +: 2];

  p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= last);

  p_wrap_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && disp_on && duty_sel == duty_q && phase == last)
      |=> (phase == 2'd0 && pol != $past(pol)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && disp_on && duty_sel == duty_q) |=> ($stable(phase) && $stable(pol)));

  p_off_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |=> (phase == 2'd0 && !pol));

  p_duty_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_sel != duty_q) |=> (phase == 2'd0 && !pol && duty_q == $past(duty_sel)));

  p_sel_extreme_r4: assert property (@(posedge clk) disable iff (!rst_n)
    disp_on |-> (cur_com == GND || cur_com == LOW));

  p_half_no_v1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_on && half) |-> (com_lvl[1:0] != 2'b01 && com_lvl[3:2] != 2'b01 &&
                           com_lvl[5:4] != 2'b01 && com_lvl[7:6] != 2'b01));

endmodule

// File: tb/lcd_mux_seq_bench.sv
`timescale 1ns/1ps
module lcd_mux_seq_bench;
  localparam int NS = 5;
  localparam int NP = 2;
  localparam logic [NP-1:0] PM = 2'b10;

  logic clk = 0;
  logic rst_n = 0;
  logic tick = 0;
  logic [1:0] duty_sel = 0;
  logic disp_on = 0;
  logic [(NS+2)*4-1:0] seg_data = '0;
  logic [NP-1:0] port_val = '0;
  logic [7:0] com_lvl;
  logic [2*NS-1:0] seg_lvl;

  always #2.5 clk = ~clk;

  lcd_mux_seq #(.NSEG(NS), .NPORT(NP), .PORT_MASK(PM)) u_lcd_mux_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .duty_sel(duty_sel), .disp_on(disp_on),
    .seg_data(seg_data), .port_val(port_val), .com_lvl(com_lvl), .seg_lvl(seg_lvl));

  int nchk = 0, nfail = 0;
  bit done = 0;
  int ephase = 0, epol = 0, eduty = 0;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int last_ph(int d);
    return (d == 1) ? 2 : (d == 2) ? 1 : 3;
  endfunction

  function automatic int seg_code(int px);
    if (px != 0) return 3 * epol;
    if (eduty == 2) return 3 * (1 - epol);
    return 2 - epol;
  endfunction

  function automatic int com_code(int c);
    if (c == ephase) return 3 * (1 - epol);
    if (eduty == 2) return 2;
    return 1 + epol;
  endfunction

  task automatic check_all();
    for (int c = 0; c < 4; c++) begin
      int e;
      int w;
      string tg;
      bit sg;
      sg = (c == 3 && (eduty == 1 || eduty == 2)) || (c == 2 && eduty == 2);
      w = (c == 3) ? NS : NS + 1;
      e = sg ? seg_code(int'(seg_data[4*w + ephase])) : com_code(c);
      if (!disp_on) e = 0;
      tg = !disp_on ? "R2 com" : eduty == 1 ? "R7 com" : eduty == 2 ? "R8 com" :
           eduty == 3 ? "R9 com" : "R4 com";
      chk(tg, int'(com_lvl[2*c +: 2]), e);
    end
    for (int k = 0; k < NS; k++) begin
      int e;
      string tg;
      if (k < NP && PM[k]) begin
        e = port_val[k] ? 0 : 3;
        tg = "R11 port";
      end else begin
        e = disp_on ? seg_code(int'(seg_data[4*k + ephase])) : 0;
        tg = !disp_on ? "R2 seg" : eduty == 2 ? "R6 seg" : "R5 seg";
      end
      chk(tg, int'(seg_lvl[2*k +: 2]), e);
    end
  endtask

  task automatic cyc(input logic t);
    @(negedge clk);
    tick = t;
    @(posedge clk);
    if (!rst_n) begin
      eduty = 0; ephase = 0; epol = 0;
    end else if (int'(duty_sel) != eduty) begin
      eduty = int'(duty_sel); ephase = 0; epol = 0;
    end else if (!disp_on) begin
      ephase = 0; epol = 0;
    end else if (t) begin
      if (ephase == last_ph(eduty)) begin ephase = 0; epol = 1 - epol; end
      else ephase = ephase + 1;
    end
    #1;
    if (rst_n) check_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired (all requirements)");
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    port_val = 2'b11;
    repeat (3) cyc(0);
    rst_n = 1;
    cyc(0);
    chk("R1 com after reset", int'(com_lvl), 0);
    chk("R1 seg0 after reset", int'(seg_lvl[1:0]), 0);
    chk("R11 port after reset", int'(seg_lvl[3:2]), 0);

    disp_on = 1;
    seg_data = '0;
    #1;
    chk("R2 turn-on selects com0", int'(com_lvl[1:0]), 3);
    repeat (4) cyc(1);
    chk("R3 wrap flips polarity com0", int'(com_lvl[1:0]), 0);
    chk("R3 wrap flips polarity com1", int'(com_lvl[3:2]), 2);
    cyc(0);
    chk("R3 idle holds com0", int'(com_lvl[1:0]), 0);
    cyc(1);
    chk("R3 step selects com1", int'(com_lvl[3:2]), 0);
    duty_sel = 2'b01;
    cyc(1);
    chk("R10 duty change restarts com0", int'(com_lvl[1:0]), 3);
    chk("R10 duty change restarts com1", int'(com_lvl[3:2]), 1);

    for (int pat = 0; pat < 8; pat++) begin
      for (int b = 0; b < (NS+2)*4; b++) begin
        if (pat == 0) seg_data[b] = 1'b0;
        else if (pat == 1) seg_data[b] = 1'b1;
        else seg_data[b] = (((b * 7 + pat * 3) % 5) < 2) ^ pat[0];
      end
      port_val = pat[1:0];
      for (int d = 0; d < 4; d++) begin
        duty_sel = 2'(d);
        disp_on = 1;
        for (int i = 0; i < 20; i++) begin
          if (pat == 3 && i == 9) disp_on = 0;
          if (pat == 3 && i == 12) disp_on = 1;
          if (pat == 5 && i == 11) port_val = ~port_val;
          cyc((i % 3) != 2);
        end
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule